// File: doc/BRIEF.md
# I2C Slave Bus Event Flag Register

This block observes an I2C bus from the target side and records what happened on it as sticky flags in a 16-bit status word. The raw clock and data lines pass through a two-stage synchronizer. Start and stop conditions are then found on the synchronized samples. A small tracking state machine shifts in the address byte and compares its seven address bits with a programmed own address. While the block is addressed, the same state machine counts the data bytes that complete.

Software reads the status word as a full word or one byte at a time, and clears flags by writing ones. Each flag is set by a one-cycle event pulse. It stays set until software clears it or the unit enable is dropped. An interrupt request is active while the unit is enabled and any flag is set.

The tracking state machine has six states:
- ST_IDLE: the bus is free.
- ST_ADDR: the eight address-phase bits are being shifted in.
- ST_ADDR_ACK: the acknowledge clock after a matching address.
- ST_DATA: data bits are being counted.
- ST_DATA_ACK: the acknowledge clock after a data byte.
- ST_SKIP: the address did not match; the machine waits for the next condition.

Its transitions are:
- A start condition, from any state, goes to ST_ADDR.
- A stop condition, or the enable going low, goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK on the eighth SCL rise when the address matches, and to ST_SKIP when it does not.
- ST_ADDR_ACK goes to ST_DATA on the next SCL rise.
- ST_DATA goes to ST_DATA_ACK on the eighth SCL rise.
- ST_DATA_ACK goes back to ST_DATA on the next SCL rise.

Top module: `i2c_slave_evflags`

## Requirements
- R1: After reset the status word reads 0x0000. Bits 15 to 13 and the whole low byte (bits 7 to 0) always read zero.
- R2: A start condition sets bit 11. A start condition is SDA falling while SCL is high, seen on the synchronized samples.
- R3: A stop condition sets bit 10. A stop condition is SDA rising while SCL is high.
- R4: After a start, eight bits are taken MSB first on SCL rising edges. The first seven are the address and the eighth is the direction bit. Bit 8 sets when the address equals own_addr.
- R5: While addressed, bit 9 sets on the eighth SCL rise of each data byte. Data bytes after a non-matching address leave bit 9 clear.
- R6: A non-matching address after a start sets bit 12 only when start_irq_en is 1. Otherwise bit 12 stays 0.
- R7: A write with wr_be[1]=1 clears each flag in bits 12 to 8 whose wr_data bit is 1. Zero bits leave their flags unchanged, and a write with only wr_be[0] set changes nothing.
- R8: While unit_en is 0, bits 12 to 8 are cleared within one cycle and stay 0 whatever the bus does.
- R9: When a flag's set event and a clearing write fall in the same cycle, the flag ends up set.
- R10: irq is 1 exactly when unit_en is 1 and at least one of bits 12 to 8 is 1.
- R11: rd_byte gives bits 15 to 8 of the status word when rd_hi is 1, and bits 7 to 0 when rd_hi is 0. rd_word always gives the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| unit_en | input | 1 | Unit enable; 0 clears and holds all flags |
| start_irq_en | input | 1 | Enables the address-mismatch flag (bit 12) |
| own_addr | input | 7 | Programmed 7-bit target address |
| wr_en | input | 1 | Status write strobe |
| wr_be | input | 2 | Byte lanes of the write (bit 1 = upper byte) |
| wr_data | input | 16 | Write data; ones clear flags |
| rd_hi | input | 1 | Byte-read lane select |
| rd_word | output | 16 | Full status word |
| rd_byte | output | 8 | Selected status byte |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same flag in one clock: a hardware event setting it and a software write-one clearing it. The bench provokes this for the start flag. It lowers SDA while SCL is high, counts the two synchronizer edges, and holds a clearing write across exactly the edge that also sees the start pulse. The flag must then read 1. The same write moved one cycle later must leave the flag at 0. A full sweep of all 128 addresses, with start_irq_en alternating, judges the match and mismatch flags against an arithmetic comparison made in the bench.

// File: rtl/i2c_evf_pkg.sv
package i2c_evf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } trk_state_t;

    localparam int STATUS_W  = 16;
    localparam int BIT_ADDR  = 8;
    localparam int BIT_DATA  = 9;
    localparam int BIT_STOP  = 10;
    localparam int BIT_START = 11;
    localparam int BIT_MISS  = 12;
    localparam logic [STATUS_W-1:0] FLAG_MASK = 16'h1F00;

endpackage

// File: rtl/i2c_evf_sync.sv
module i2c_evf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[g] <= 1'b1;
                else if (g == 0)
                    chain[g] <= d_in;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_evf_cond.sv
module i2c_evf_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        start_ev = scl_s &  scl_q &  sda_q & ~sda_s;
        stop_ev  = scl_s &  scl_q & ~sda_q &  sda_s;
        scl_rise = scl_s & ~scl_q;
    end
endmodule

// File: rtl/i2c_evf_tracker.sv
module i2c_evf_tracker
    import i2c_evf_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int BYTE_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              scl_rise,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              addr_hit,
    output logic              addr_miss,
    output logic              byte_done
);
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

    trk_state_t state, state_nx;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-2:0] shreg;
    logic                 last_rise;
    logic                 match;

    assign last_rise = scl_rise && (bit_cnt == LAST_BIT);
    assign match     = (shreg[ADDR_W-1:0] == own_addr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // bit counter and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!enable || start_ev || stop_ev) begin
            bit_cnt <= '0;
        end else if (scl_rise && (state == ST_ADDR || state == ST_DATA)) begin
            bit_cnt <= last_rise ? '0 : bit_cnt + 1'b1;
            shreg   <= {shreg[BYTE_BITS-3:0], sda_s};
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!enable || stop_ev) begin
            state_nx = ST_IDLE;
        end else if (start_ev) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (last_rise) state_nx = match ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_rise)  state_nx = ST_DATA;
                ST_DATA:     if (last_rise) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_rise)  state_nx = ST_DATA;
                ST_SKIP:     state_nx = ST_SKIP;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // event outputs
    always_comb begin
        addr_hit  = 1'b0;
        addr_miss = 1'b0;
        byte_done = 1'b0;
        if (enable && !start_ev && !stop_ev) begin
            unique case (state)
                ST_ADDR: begin
                    addr_hit  = last_rise &&  match;
                    addr_miss = last_rise && !match;
                end
                ST_DATA:  byte_done = last_rise;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_evf_flags.sv
module i2c_evf_flags
    import i2c_evf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [STATUS_W-1:0] set_vec,
    input  logic [STATUS_W-1:0] clr_vec,
    output logic [STATUS_W-1:0] status
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= '0;
        else if (!enable)
            status <= '0;
        else
            status <= ((status & ~clr_vec) | set_vec) & FLAG_MASK;
    end
endmodule

// File: rtl/i2c_slave_evflags.sv
module i2c_slave_evflags
    import i2c_evf_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              unit_en,
    input  logic              start_irq_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [15:0]       wr_data,
    input  logic              rd_hi,
    output logic [15:0]       rd_word,
    output logic [7:0]        rd_byte,
    output logic              irq
);
    logic scl_s, sda_s;
    logic start_ev, stop_ev, scl_rise;
    logic addr_hit, addr_miss, byte_done;
    logic [STATUS_W-1:0] set_vec, clr_vec, status;

    i2c_evf_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .d_out(scl_s));
    i2c_evf_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .d_out(sda_s));

    i2c_evf_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise));

    i2c_evf_tracker #(.ADDR_W(ADDR_W), .BYTE_BITS(ADDR_W + 1)) u_trk (
        .clk(clk), .rst_n(rst_n), .enable(unit_en),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
        .sda_s(sda_s), .own_addr(own_addr),
        .addr_hit(addr_hit), .addr_miss(addr_miss), .byte_done(byte_done));

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_ADDR]  = addr_hit;
        set_vec[BIT_DATA]  = byte_done;
        set_vec[BIT_STOP]  = stop_ev;
        set_vec[BIT_START] = start_ev;
        set_vec[BIT_MISS]  = addr_miss & start_irq_en;
        clr_vec = wr_en ? (wr_data & {{8{wr_be[1]}}, {8{wr_be[0]}}}) : '0;
    end

    i2c_evf_flags u_flags (
        .clk(clk), .rst_n(rst_n), .enable(unit_en),
        .set_vec(set_vec), .clr_vec(clr_vec), .status(status));

    assign rd_word = status;
    assign rd_byte = rd_hi ? status[15:8] : status[7:0];
    assign irq     = unit_en & (|status[BIT_MISS:BIT_ADDR]);
endmodule

// File: rtl/i2c_slave_evflags_chk.sv
module i2c_slave_evflags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        unit_en,
    input logic        start_irq_en,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic        rd_hi,
    input logic [15:0] rd_word,
    input logic [7:0]  rd_byte,
    input logic        irq
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word & 16'hE0FF) == 16'h0000);

    assert_miss_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_word[12]) |-> $past(start_irq_en));

    assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && rd_word[11] && !(wr_en && wr_be[1] && wr_data[11])) |=> rd_word[11]);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (rd_word[12:8] == 5'd0));

    assert_irq_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> !irq);

    assert_byte_lane_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_byte == (rd_hi ? rd_word[15:8] : rd_word[7:0]));
endmodule

bind i2c_slave_evflags i2c_slave_evflags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .start_irq_en(start_irq_en),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_hi(rd_hi),
    .rd_word(rd_word), .rd_byte(rd_byte), .irq(irq));

// File: tb/i2c_slave_evflags_test.sv
module i2c_slave_evflags_test;
    localparam int PH = 4;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic unit_en = 1'b0, start_irq_en = 1'b0;
    logic [6:0] own_addr = OWN;
    logic wr_en = 1'b0;
    logic [1:0] wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic rd_hi = 1'b0;
    logic [15:0] rd_word;
    logic [7:0] rd_byte;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2c_slave_evflags uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .unit_en(unit_en), .start_irq_en(start_irq_en), .own_addr(own_addr),
        .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .rd_hi(rd_hi),
        .rd_word(rd_word), .rd_byte(rd_byte), .irq(irq));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_in = 1'b1; scl_in = 1'b1; wait_ph();
        sda_in = 1'b0; wait_ph();
        scl_in = 1'b0; wait_ph();
    endtask

    task automatic bus_stop();
        sda_in = 1'b0; wait_ph();
        scl_in = 1'b1; wait_ph();
        sda_in = 1'b1; wait_ph();
    endtask

    task automatic bus_bit(input logic b);
        sda_in = b; wait_ph();
        scl_in = 1'b1; wait_ph();
        scl_in = 1'b0; wait_ph();
    endtask

    task automatic bus_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        bus_bit(1'b1);
    endtask

    task automatic sw_write(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", rd_word, 16'h0000);
        chk("R10 reset irq", {15'd0, irq}, 16'h0);
        rst_n = 1'b1;
        unit_en = 1'b1;
        wait_ph();

        // R4 R5 R6 R2 R3 R10: sweep every address, alternating start_irq_en
        for (int a = 0; a < 128; a++) begin
            logic m;
            logic [15:0] e;
            m = (a[6:0] == OWN);
            start_irq_en = a[0];
            sw_write(2'b10, 16'h1F00);
            bus_start();
            chk("R2 start flag", {15'd0, rd_word[11]}, 16'd1);
            bus_byte({a[6:0], a[1]});
            e = 16'h0800 | (m ? 16'h0100 : 16'h0) | ((!m && a[0]) ? 16'h1000 : 16'h0);
            chk("R4/R6 address flags", rd_word, e);
            chk("R10 irq", {15'd0, irq}, 16'd1);
            bus_byte(8'h5A ^ a[7:0]);
            if (m) e = e | 16'h0200;
            chk("R5 data flag", rd_word, e);
            bus_stop();
            chk("R3 stop flag", rd_word, e | 16'h0400);
        end

        // R7: zero bits and low lane do nothing; ones clear
        start_irq_en = 1'b1;
        sw_write(2'b10, 16'h1F00);
        own_addr = 7'h11;
        bus_start(); bus_byte({7'h11, 1'b0}); bus_byte(8'h00); bus_stop();
        chk("R7 set all but miss", rd_word, 16'h0F00);
        sw_write(2'b10, 16'h0000);
        chk("R7 zero write", rd_word, 16'h0F00);
        sw_write(2'b01, 16'hFFFF);
        chk("R7 low lane write", rd_word, 16'h0F00);
        sw_write(2'b10, 16'h0500);
        chk("R7 partial clear", rd_word, 16'h0A00);
        // R11 byte reads
        rd_hi = 1'b1; @(negedge clk);
        chk("R11 high byte", {8'h0, rd_byte}, 16'h000A);
        rd_hi = 1'b0; @(negedge clk);
        chk("R11 low byte", {8'h0, rd_byte}, 16'h0000);
        sw_write(2'b11, 16'hFFFF);
        chk("R7 clear all", rd_word, 16'h0000);
        chk("R10 irq low", {15'd0, irq}, 16'd0);

        // R9: start set and clearing write in the same cycle
        scl_in = 1'b1; sda_in = 1'b1; wait_ph();
        sda_in = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h0800;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
        chk("R9 set wins", {15'd0, rd_word[11]}, 16'd1);
        sw_write(2'b10, 16'h0800);
        chk("R9 later clear", {15'd0, rd_word[11]}, 16'd0);
        scl_in = 1'b0; wait_ph();
        bus_stop();
        sw_write(2'b10, 16'h1F00);

        // R8: disable clears and blocks
        bus_start(); bus_byte({7'h11, 1'b1});
        unit_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R8 disable clears", rd_word, 16'h0000);
        chk("R10 irq when disabled", {15'd0, irq}, 16'd0);
        bus_byte(8'hFF); bus_stop();
        bus_start(); bus_byte({7'h11, 1'b0}); bus_stop();
        chk("R8 held clear", rd_word, 16'h0000);
        unit_en = 1'b1; wait_ph();
        chk("R1 after re-enable", rd_word, 16'h0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule